// File: doc/BRIEF.md
# Invertible-Set Read Decoder

This block recovers logical data from a raw read of a resistive memory block that is protected against stuck-at cells. The block's cells are arranged as a grid of rows and columns. The write side stores the data with a chosen set of cells inverted, so that every cell stuck at the wrong value lines up with an inversion. That set is described by one small saturating counter per row and one per column.

On a read, the decoder receives the raw cell values together with the stored row and column counters. For each cell it takes the smaller of that cell's row counter and column counter. It inverts the cell when that minimum is odd and passes it through when the minimum is even. Stuck cells are treated like any other cell, because the decoder needs no knowledge of which cells are faulty.

The mapping is pure combinational logic into one output register. Corrected data is presented with a valid strobe one clock after the read strobe. Grid dimensions and counter capacity are parameters.

Top module: `invset_read_decoder`

## Requirements
- R1: While `rst` is high at a rising clock edge, `dout_valid` and `dout` are 0 after that edge.
- R2: `dout_valid` after a rising edge equals the value `rd_valid` had at that edge, so it follows the read strobe with a delay of exactly one clock.
- R3: The cell at row r and column c is bit r*COLS+c of `raw_cells` and of `dout`. Row r's counter is `row_cnt[r*CNT_W +: CNT_W]` and column c's counter is `col_cnt[c*CNT_W +: CNT_W]`. When the smaller of the two counters is odd, the output bit is the inverse of the raw bit.
- R4: When the smaller of a cell's two counters is even, including zero, the output bit equals the raw bit. With all counters at zero, `dout` equals `raw_cells`.
- R5: The decision uses the minimum of the two counters and not their sum or maximum. A cell with counters 2 and 3 is passed unchanged.
- R6: When `rd_valid` is low at an edge, `dout` keeps its previous value whatever the other inputs do.
- R7: For any stored pattern produced by an encoder that leaves no cell stuck at the wrong value, decoding with that encoder's counters returns the original data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_valid | input | 1 | Raw read data and counters are valid this cycle |
| raw_cells | input | ROWS*COLS | Raw cell values, bit r*COLS+c is row r column c |
| row_cnt | input | ROWS*CNT_W | Packed row counters, row r at r*CNT_W |
| col_cnt | input | COLS*CNT_W | Packed column counters, column c at c*CNT_W |
| dout_valid | output | 1 | Corrected data valid |
| dout | output | ROWS*COLS | Corrected data word |

## Verification
Both corrected data and its valid strobe are due one clock after the read strobe is sampled, with no cycle in which the data is valid but not yet stable. The bench drives inputs on the falling edge and reads results on the following falling edge, half a period after the capturing rising edge, so every result is sampled exactly one register stage after its stimulus. Hold and reset checks wait further falling edges and look at the ports with the read strobe low or reset high. The round-trip checks model an encoder in the bench and compare the decoded word against the original data, not against any copy of the mapping.

// File: rtl/invset_pkg.sv
package invset_pkg;
  // True when the smaller of two unsigned counter values is odd.
  function automatic logic min_is_odd(input logic [15:0] a, input logic [15:0] b);
    logic [15:0] m;
    m = (a < b) ? a : b;
    return m[0];
  endfunction
endpackage

// File: rtl/invset_flip_mask.sv
module invset_flip_mask #(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int CNT_W = 2
) (
  input  logic [ROWS*CNT_W-1:0] row_cnt,
  input  logic [COLS*CNT_W-1:0] col_cnt,
  output logic [ROWS*COLS-1:0]  flip
);
  import invset_pkg::*;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      logic [CNT_W-1:0] rv, cv;
      assign rv = row_cnt[r*CNT_W +: CNT_W];
      assign cv = col_cnt[c*CNT_W +: CNT_W];
      assign flip[r*COLS+c] = min_is_odd(16'(rv), 16'(cv));

      // R4: a zero counter on either side never inverts the cell
      always_comb begin
        if (flip[r*COLS+c]) begin
          p_zero_cnt_pass_r4: assert (rv != '0 && cv != '0);
        end
      end
    end
  end
endmodule

// File: rtl/invset_out_reg.sv
module invset_out_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         q_valid,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q       <= '0;
    end else begin
      q_valid <= load;
      if (load) q <= din;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (!q_valid && q == '0));
  p_valid_rise_r2:  assert property (@(posedge clk) disable iff (rst) load |=> q_valid);
  p_valid_fall_r2:  assert property (@(posedge clk) disable iff (rst) !load |=> !q_valid);
  p_capture_r3:     assert property (@(posedge clk) disable iff (rst) load |=> q == $past(din));
  p_hold_r6:        assert property (@(posedge clk) disable iff (rst) !load |=> $stable(q));
endmodule

// File: rtl/invset_read_decoder.sv
module invset_read_decoder #(
  parameter int ROWS    = 4,
  parameter int COLS    = 4,
  parameter int CNT_MAX = 3,
  localparam int CNT_W  = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX + 1),
  localparam int CELLS  = ROWS * COLS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_valid,
  input  logic [CELLS-1:0]      raw_cells,
  input  logic [ROWS*CNT_W-1:0] row_cnt,
  input  logic [COLS*CNT_W-1:0] col_cnt,
  output logic                  dout_valid,
  output logic [CELLS-1:0]      dout
);
  logic [CELLS-1:0] flip;
  logic [CELLS-1:0] fixed;

  invset_flip_mask #(.ROWS(ROWS), .COLS(COLS), .CNT_W(CNT_W)) i_mask (
    .row_cnt (row_cnt),
    .col_cnt (col_cnt),
    .flip    (flip)
  );

  assign fixed = raw_cells ^ flip;

  invset_out_reg #(.W(CELLS)) i_oreg (
    .clk     (clk),
    .rst     (rst),
    .load    (rd_valid),
    .din     (fixed),
    .q_valid (dout_valid),
    .q       (dout)
  );
endmodule

// File: tb/test_invset_read_decoder.sv
module test_invset_read_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 4, COLS = 4, CW = 2, N = 16;

  logic clk = 0, rst = 1, rd_valid = 0;
  logic [N-1:0] raw_cells = '0;
  logic [ROWS*CW-1:0] row_cnt = '0;
  logic [COLS*CW-1:0] col_cnt = '0;
  logic dout_valid;
  logic [N-1:0] dout;
  int checks = 0, fails = 0;

  invset_read_decoder #(.ROWS(ROWS), .COLS(COLS), .CNT_MAX(3)) i_invset_read_decoder (
    .clk(clk), .rst(rst), .rd_valid(rd_valid), .raw_cells(raw_cells),
    .row_cnt(row_cnt), .col_cnt(col_cnt), .dout_valid(dout_valid), .dout(dout));

  always #(CLK_PERIOD/2) clk = ~clk;

  // {raw, row counters, column counters, expected}
  localparam logic [47:0] VEC [6] = '{
    {16'hA5C3, 8'h00, 8'h00, 16'hA5C3},  // R4 all zero counters
    {16'h0000, 8'hFF, 8'h55, 16'hFFFF},  // R3 min 1 everywhere
    {16'h1234, 8'hAA, 8'hFF, 16'h1234},  // R5 min(2,3)=2 even
    {16'h0000, 8'h01, 8'hFF, 16'h000F},  // R3 row 0 only
    {16'hFFFF, 8'hFF, 8'h10, 16'hBBBB},  // R3 column 2 only
    {16'h0000, 8'hE4, 8'hE4, 16'hA2E0}   // R3 R5 mixed counters
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read(input logic [N-1:0] r, input logic [7:0] rc, input logic [7:0] cc);
    @(negedge clk);
    raw_cells = r; row_cnt = rc; col_cnt = cc; rd_valid = 1;
    @(negedge clk);
    rd_valid = 0;
  endtask

  // Encoder model: raise counters of rows/columns holding wrong-stuck cells
  function automatic bit encode(input logic [N-1:0] data, input logic [N-1:0] smask,
                                input logic [N-1:0] sval, output logic [N-1:0] stored,
                                output logic [7:0] rco, output logic [7:0] cco);
    int rc[ROWS], cc[COLS];
    foreach (rc[i]) rc[i] = 0;
    foreach (cc[i]) cc[i] = 0;
    for (int it = 0; it < 8; it++) begin
      logic [N-1:0] want, wrong;
      bit rhit[ROWS], chit[COLS];
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          want[r*COLS+c] = data[r*COLS+c] ^ (((rc[r] < cc[c]) ? rc[r] : cc[c]) % 2 == 1);
      stored = (want & ~smask) | (sval & smask);
      wrong = stored ^ want;
      for (int i = 0; i < ROWS; i++) rco[i*CW +: CW] = CW'(rc[i]);
      for (int i = 0; i < COLS; i++) cco[i*CW +: CW] = CW'(cc[i]);
      if (wrong == '0) return 1;
      foreach (rhit[i]) rhit[i] = 0;
      foreach (chit[i]) chit[i] = 0;
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          if (wrong[r*COLS+c]) begin rhit[r] = 1; chit[c] = 1; end
      for (int i = 0; i < ROWS; i++) if (rhit[i]) begin if (rc[i] == 3) return 0; rc[i]++; end
      for (int i = 0; i < COLS; i++) if (chit[i]) begin if (cc[i] == 3) return 0; cc[i]++; end
    end
    return 0;
  endfunction

  initial begin
    #(CLK_PERIOD*20000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int ok_trips;
    rd_valid = 1; raw_cells = 16'hFFFF;
    repeat (3) @(negedge clk);
    chk(dout_valid == 0 && dout == 0, "R1 reset", {15'd0, dout_valid, dout}, 0);
    rd_valid = 0;
    @(negedge clk); rst = 0;

    foreach (VEC[k]) begin
      read(VEC[k][47:32], VEC[k][31:24], VEC[k][23:16]);
      chk(dout_valid == 1, "R2 valid one cycle after strobe", 32'(dout_valid), 1);
      chk(dout == VEC[k][15:0], "R3 R4 R5 vector", 32'(dout), 32'(VEC[k][15:0]));
    end

    // R2 / R6: strobe low, inputs change, output holds
    @(negedge clk);
    raw_cells = 16'h5A5A; row_cnt = 8'h55; col_cnt = 8'h55;
    @(negedge clk);
    chk(dout_valid == 0, "R2 valid drops", 32'(dout_valid), 0);
    chk(dout == 16'hA2E0, "R6 hold without strobe", 32'(dout), 32'hA2E0);

    // R1 reset while reading
    @(negedge clk); rd_valid = 1; rst = 1;
    @(negedge clk);
    chk(dout_valid == 0 && dout == 0, "R1 reset during read", {15'd0, dout_valid, dout}, 0);
    rst = 0; rd_valid = 0;

    // R7 round trip with random stuck cells
    ok_trips = 0;
    for (int t = 0; t < 60; t++) begin
      logic [N-1:0] d, sm, sv, st;
      logic [7:0] rco, cco;
      d = 16'($urandom); sv = 16'($urandom); sm = '0;
      for (int f = 0; f < (t % 5); f++) sm[$urandom % N] = 1'b1;
      if (encode(d, sm, sv, st, rco, cco)) begin
        ok_trips++;
        read(st, rco, cco);
        chk(dout == d, "R7 round trip", 32'(dout), 32'(d));
      end
    end
    chk(ok_trips > 20, "R7 enough encodable patterns", ok_trips, 20);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule